// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the timing signals for a raster display. Every horizontal and vertical interval comes from a register, so one instance can drive many monitor formats. The horizontal position counts pixel-clock groups, where one group is one clock of `clk`. The vertical position counts half-lines rather than whole lines. This allows equalizing pulses and serrated broad sync pulses to be produced, as in interlace-capable composite sync.

Software first loads the timing registers while the generator is stopped, then sets the run bit. While the block runs it walks each frame in a fixed order: pre-equalization, vertical sync (broad pulses), post-equalization, the remainder of vertical blanking, and then the visible lines. After the visible lines it wraps back to the start of the frame. The outputs are:
- a composite sync waveform;
- a vertical-sync region flag;
- a blanking signal;
- a display-active signal;
- a one-cycle strobe at a programmable point of every line.

Top module: `raster_timer`

## Requirements
- R1: After reset the run bit is 0, and the outputs hold their idle values: `syncOut`=0, `vSyncOut`=0, `blankOut`=1, `dispActive`=0 and `lineStrobe`=0. They keep these values in every cycle in which the run bit is 0.
- R2: A write with `wrEn`=1 at a clock edge stores `wrData` at `wrAddr`. The register map is:
  - 0: control, where bit 0 is the run bit;
  - 1: half-sync width;
  - 2: back porch;
  - 3: display width;
  - 4: broad-pulse width;
  - 5: line time;
  - 6: line-strobe position;
  - 7: pre-equalize length;
  - 8: v-sync length;
  - 9: post-equalize length;
  - 10: v-blank length;
  - 11: v-display length.

  Writes to addresses 1 to 11 are ignored while the run bit is 1. Writes to address 0 are always accepted.
- R3: In the clock after the edge that sets the run bit, the horizontal count is 0. It then advances by 1 per clock, wrapping from line time − 1 to 0. After the run bit is cleared, the next run restarts at the top of the frame.
- R4: In the remainder-of-blanking and visible regions, `syncOut` is 1 exactly when the horizontal count is below twice the half-sync width. There is no pulse at mid-line.
- R5: The horizontal display window covers counts from 2·halfSync + backPorch up to, but not including, 2·halfSync + backPorch + dispWidth.
- R6: The vertical count advances by one half-line at horizontal counts lineTime/2 − 1 and lineTime − 1. A frame lasts vBlank + vDisp half-lines and then wraps to half-line 0.
- R7: With P, S and Q the pre-equalize, v-sync and post-equalize lengths, the vertical regions are:
  - pre-equalize: half-lines [0, P);
  - v-sync: [P, P+S);
  - post-equalize: [P+S, P+S+Q);
  - remainder of blanking: up to vBlank;
  - visible lines: [vBlank, vBlank+vDisp).

  A region of length zero is skipped.
- R8: In the pre-equalize and post-equalize regions, `syncOut` is 1 for the first half-sync-width counts of each half-line.
- R9: In the v-sync region, `syncOut` is 1 for the first broad-pulse-width counts of each half-line, and `vSyncOut` is 1 for the whole region.
- R10: `dispActive` is 1 only when the horizontal display window and the visible-lines region are both active. `blankOut` is its inverse.
- R11: `lineStrobe` is 1 for exactly the cycle in which the horizontal count equals the line-strobe position, in every region while the generator runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-group clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write enable |
| wrAddr | input | ADDR_W (4) | Register address |
| wrData | input | DATA_W (12) | Register write data |
| syncOut | output | 1 | Composite sync, active high |
| vSyncOut | output | 1 | High during the v-sync region |
| blankOut | output | 1 | High when the pixel is not displayed |
| dispActive | output | 1 | High inside the visible area |
| lineStrobe | output | 1 | One-cycle pulse at the programmed line position |

## Verification
On every cycle, the assertions check the following:
- the outputs stay idle while the generator is stopped;
- the timing registers stay frozen while it runs;
- the horizontal count steps by one and stays below the line time;
- the vertical count wraps at the frame end;
- vertical sync never overlaps the visible area;
- the line strobe lasts a single cycle.

The shape of each waveform can only be shown by the bench's scenarios. These cover the equalizing pulses at every half-line, the broad pulses, the absence of a mid-line pulse in ordinary lines, the exact edges of the display window, the frame wrap, the skipping of a zero-length region, and the fact that a line-time write made while running has no effect.

// File: rtl/rt_pkg.sv
package rt_pkg;
  parameter int H_W = 12;
  parameter int V_W = 12;

  typedef enum logic [2:0] {
    V_PRE   = 3'd0,
    V_SYNC  = 3'd1,
    V_POST  = 3'd2,
    V_BLANK = 3'd3,
    V_DISP  = 3'd4
  } vRegion_t;

  typedef struct packed {
    logic [H_W-1:0] halfSync;
    logic [H_W-1:0] backPorch;
    logic [H_W-1:0] dispWidth;
    logic [H_W-1:0] broadPulse;
    logic [H_W-1:0] lineTime;
    logic [H_W-1:0] lineStart;
    logic [V_W-1:0] vPreEq;
    logic [V_W-1:0] vSyncLen;
    logic [V_W-1:0] vPostEq;
    logic [V_W-1:0] vBlank;
    logic [V_W-1:0] vDisp;
  } timingCfg_t;

  // Strobes and state handed from the control to the datapath
  typedef struct packed {
    logic     running;
    logic     secondHalf;
    vRegion_t region;
  } ctrlStrobe_t;
endpackage

// File: rtl/rt_regs.sv
module rt_regs import rt_pkg::*; #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output timingCfg_t        cfg,
  output logic              run
);
  localparam logic [ADDR_W-1:0] ADR_CTRL   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADR_HSYNC  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADR_BPORCH = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] ADR_DWIDTH = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] ADR_BROAD  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] ADR_LTIME  = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] ADR_LSTART = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] ADR_VPRE   = ADDR_W'(7);
  localparam logic [ADDR_W-1:0] ADR_VSYNC  = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] ADR_VPOST  = ADDR_W'(9);
  localparam logic [ADDR_W-1:0] ADR_VBLANK = ADDR_W'(10);
  localparam logic [ADDR_W-1:0] ADR_VDISP  = ADDR_W'(11);

  logic [H_W-1:0] hData;
  logic [V_W-1:0] vData;
  assign hData = H_W'(wrData);
  assign vData = V_W'(wrData);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg <= '0;
      run <= 1'b0;
    end else if (wrEn) begin
      if (wrAddr == ADR_CTRL) begin
        run <= wrData[0];
      end else if (!run) begin
        case (wrAddr)
          ADR_HSYNC:  cfg.halfSync   <= hData;
          ADR_BPORCH: cfg.backPorch  <= hData;
          ADR_DWIDTH: cfg.dispWidth  <= hData;
          ADR_BROAD:  cfg.broadPulse <= hData;
          ADR_LTIME:  cfg.lineTime   <= hData;
          ADR_LSTART: cfg.lineStart  <= hData;
          ADR_VPRE:   cfg.vPreEq     <= vData;
          ADR_VSYNC:  cfg.vSyncLen   <= vData;
          ADR_VPOST:  cfg.vPostEq    <= vData;
          ADR_VBLANK: cfg.vBlank     <= vData;
          ADR_VDISP:  cfg.vDisp      <= vData;
          default: ;
        endcase
      end
    end
  end

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    run |=> $stable(cfg)); // R2
endmodule

// File: rtl/rt_ctrl.sv
module rt_ctrl import rt_pkg::*; (
  input  logic           clk,
  input  logic           rstN,
  input  logic           run,
  input  timingCfg_t     cfg,
  output logic [H_W-1:0] hCnt,
  output ctrlStrobe_t    strobe
);
  localparam int VX_W = V_W + 2;

  logic [V_W-1:0] vCnt;
  logic [H_W-1:0] hNext;
  logic [V_W-1:0] vNext;
  logic [H_W-1:0] halfLen;
  logic [V_W:0]   frameLen;
  logic           lineEnd;
  logic           midEnd;
  logic           frameEnd;
  logic           stepV;
  vRegion_t       region;
  logic           secondHalf;

  function automatic vRegion_t regionOf(input logic [V_W-1:0] v, input timingCfg_t c);
    logic [VX_W-1:0] vx, e1, e2, e3, eb;
    vx = VX_W'(v);
    e1 = VX_W'(c.vPreEq);
    e2 = e1 + VX_W'(c.vSyncLen);
    e3 = e2 + VX_W'(c.vPostEq);
    eb = VX_W'(c.vBlank);
    if (vx < e1)      return V_PRE;
    else if (vx < e2) return V_SYNC;
    else if (vx < e3) return V_POST;
    else if (vx < eb) return V_BLANK;
    else              return V_DISP;
  endfunction

  assign halfLen  = cfg.lineTime >> 1;
  assign lineEnd  = (hCnt == cfg.lineTime - 1'b1);
  assign midEnd   = (hCnt == halfLen - 1'b1);
  assign stepV    = lineEnd || midEnd;
  assign frameLen = {1'b0, cfg.vBlank} + {1'b0, cfg.vDisp};
  assign frameEnd = ({1'b0, vCnt} == frameLen - 1'b1);

  always_comb begin
    if (!run) begin
      hNext = '0;
      vNext = '0;
    end else begin
      hNext = lineEnd ? '0 : hCnt + 1'b1;
      if (stepV) vNext = frameEnd ? '0 : vCnt + 1'b1;
      else       vNext = vCnt;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCnt       <= '0;
      vCnt       <= '0;
      region     <= V_PRE;
      secondHalf <= 1'b0;
    end else begin
      hCnt       <= hNext;
      vCnt       <= vNext;
      region     <= regionOf(vNext, cfg);
      secondHalf <= run && (hNext >= halfLen);
    end
  end

  always_comb begin
    strobe.running    = run;
    strobe.secondHalf = secondHalf;
    strobe.region     = region;
  end

  AST_H_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (run && cfg.lineTime != '0) |-> (hCnt < cfg.lineTime)); // R3
  AST_H_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (run && !lineEnd) |=> (hCnt == $past(hCnt) + 1'b1)); // R3
  AST_V_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (run && stepV && frameEnd) |=> (vCnt == '0)); // R6
endmodule

// File: rtl/rt_dpath.sv
module rt_dpath import rt_pkg::*; (
  input  logic           clk,
  input  logic           rstN,
  input  timingCfg_t     cfg,
  input  logic [H_W-1:0] hCnt,
  input  ctrlStrobe_t    strobe,
  output logic           syncOut,
  output logic           vSyncOut,
  output logic           blankOut,
  output logic           dispActive,
  output logic           lineStrobe
);
  localparam int HX_W = H_W + 2;

  logic [H_W-1:0]  halfLen;
  logic [H_W-1:0]  halfPos;
  logic [HX_W-1:0] hx, syncEnd, winStart, winStop;
  logic            hWin;
  logic            syncRaw;

  assign halfLen  = cfg.lineTime >> 1;
  assign halfPos  = strobe.secondHalf ? (hCnt - halfLen) : hCnt;
  assign hx       = HX_W'(hCnt);
  assign syncEnd  = HX_W'(cfg.halfSync) << 1;
  assign winStart = syncEnd + HX_W'(cfg.backPorch);
  assign winStop  = winStart + HX_W'(cfg.dispWidth);
  assign hWin     = (hx >= winStart) && (hx < winStop);

  always_comb begin
    case (strobe.region)
      V_PRE, V_POST: syncRaw = (halfPos < cfg.halfSync);
      V_SYNC:        syncRaw = (halfPos < cfg.broadPulse);
      default:       syncRaw = (hx < syncEnd);
    endcase
  end

  assign syncOut    = strobe.running && syncRaw;
  assign vSyncOut   = strobe.running && (strobe.region == V_SYNC);
  assign dispActive = strobe.running && (strobe.region == V_DISP) && hWin;
  assign blankOut   = !dispActive;
  assign lineStrobe = strobe.running && (hCnt == cfg.lineStart);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.running |-> (blankOut && !syncOut && !vSyncOut && !lineStrobe)); // R1
  AST_VSYNC_BLANKED: assert property (@(posedge clk) disable iff (!rstN)
    vSyncOut |-> blankOut); // R10
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (lineStrobe && strobe.running && cfg.lineTime > 1) |=> !lineStrobe); // R11
endmodule

// File: rtl/raster_timer.sv
module raster_timer import rt_pkg::*; #(
  parameter int ADDR_W = 4,
  localparam int DATA_W = (H_W > V_W) ? H_W : V_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              syncOut,
  output logic              vSyncOut,
  output logic              blankOut,
  output logic              dispActive,
  output logic              lineStrobe
);
  timingCfg_t     cfg;
  logic           run;
  logic [H_W-1:0] hCnt;
  ctrlStrobe_t    strobe;

  rt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cfg(cfg), .run(run)
  );

  rt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .run(run), .cfg(cfg), .hCnt(hCnt), .strobe(strobe)
  );

  rt_dpath u_dpath (
    .clk(clk), .rstN(rstN), .cfg(cfg), .hCnt(hCnt), .strobe(strobe),
    .syncOut(syncOut), .vSyncOut(vSyncOut), .blankOut(blankOut),
    .dispActive(dispActive), .lineStrobe(lineStrobe)
  );
endmodule

// File: tb/raster_timer_bench.sv
`timescale 1ns/1ps
module raster_timer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [11:0] wrData = '0;
  logic syncOut, vSyncOut, blankOut, dispActive, lineStrobe;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  raster_timer u_raster_timer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .syncOut(syncOut), .vSyncOut(vSyncOut), .blankOut(blankOut),
    .dispActive(dispActive), .lineStrobe(lineStrobe)
  );

  // Row: {time after run 8b, requirement 4b, expected {sync,vsync,blank,disp,strobe}}
  // Config: halfSync 2, backPorch 3, dispWidth 8, broad 5, lineTime 20, strobe at 1,
  // pre 2, vsync 2, post 2, vBlank 8, vDisp 4 half-lines.
  localparam int NV = 23;
  localparam logic [16:0] VEC [NV] = '{
    {8'd0,   4'd8,  5'b10100},  // R8 pre-eq pulse at half-line start
    {8'd1,   4'd11, 5'b10101},  // R11 strobe
    {8'd2,   4'd8,  5'b00100},  // R8 pulse ends after halfSync
    {8'd10,  4'd8,  5'b10100},  // R8 mid-line equalize pulse
    {8'd12,  4'd8,  5'b00100},
    {8'd20,  4'd9,  5'b11100},  // R9 broad pulse
    {8'd24,  4'd9,  5'b11100},
    {8'd25,  4'd9,  5'b01100},
    {8'd34,  4'd9,  5'b11100},
    {8'd35,  4'd9,  5'b01100},
    {8'd40,  4'd7,  5'b10100},  // R7 post-eq
    {8'd50,  4'd7,  5'b10100},
    {8'd52,  4'd7,  5'b00100},
    {8'd61,  4'd11, 5'b10101},  // R11 strobe in blank region
    {8'd70,  4'd4,  5'b00100},  // R4 no mid-line pulse
    {8'd83,  4'd4,  5'b10100},  // R4 last sync count
    {8'd87,  4'd5,  5'b00010},  // R5 window opens
    {8'd94,  4'd5,  5'b00010},
    {8'd95,  4'd5,  5'b00100},  // R5 window closes
    {8'd107, 4'd10, 5'b00010},  // R10
    {8'd119, 4'd6,  5'b00100},  // R6 last count of frame
    {8'd120, 4'd6,  5'b10100},  // R6 wrap
    {8'd127, 4'd10, 5'b00100}   // R10 vertical gating
  };

  function automatic logic [4:0] obs();
    return {syncOut, vSyncOut, blankOut, dispActive, lineStrobe};
  endfunction

  task automatic chk(input int req, input logic [4:0] exp);
    checks++;
    if (obs() !== exp) begin
      errors++;
      $display("FAIL R%0d: got %b expected %b at %0t", req, obs(), exp, $time);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [11:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitTo(inout int cur, input int t);
    repeat (t - cur) @(negedge clk);
    cur = t;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cur;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(1, 5'b00100); // R1 reset state

    wr(4'd1, 12'd2);  wr(4'd2, 12'd3);  wr(4'd3, 12'd8);
    wr(4'd4, 12'd5);  wr(4'd5, 12'd20); wr(4'd6, 12'd1);
    wr(4'd7, 12'd2);  wr(4'd8, 12'd2);  wr(4'd9, 12'd2);
    wr(4'd10, 12'd8); wr(4'd11, 12'd4);
    chk(1, 5'b00100); // R1 stays idle while stopped

    wr(4'd0, 12'd1);
    cur = 0;
    for (int i = 0; i < NV; i++) begin
      waitTo(cur, int'(VEC[i][16:9]));
      chk(int'(VEC[i][8:5]), VEC[i][4:0]);
    end

    // R2: line-time write while running is ignored
    wr(4'd5, 12'd40);
    wr(4'd0, 12'd0);
    chk(3, 5'b00100); // R3 stopped generator is idle
    wr(4'd0, 12'd1);
    cur = 0;
    chk(3, 5'b10100); // R3 restart at frame top
    waitTo(cur, 21);
    chk(2, 5'b11101); // R2 line time still 20

    // R7: zero-length pre-equalize region is skipped
    wr(4'd0, 12'd0);
    wr(4'd7, 12'd0);
    wr(4'd0, 12'd1);
    cur = 0;
    chk(7, 5'b11100);
    waitTo(cur, 25);
    chk(7, 5'b00100);
    waitTo(cur, 40);
    chk(7, 5'b10100);
    waitTo(cur, 50);
    chk(4, 5'b00100);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule